// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Guarded Writes

This block is a watchdog peripheral on a simple register bus. When software enables it, a first countdown runs from its preload value. When the first countdown runs out, an interrupt can be raised and a second countdown starts from its own preload value. When the second countdown runs out, the block sets a sticky timeout flag and drives a reset request. Software keeps the system alive by reloading the first countdown before it runs out.

Writes to the two preload registers and to the kick register are guarded. Each guarded write must follow a two-write key sequence (0x080, then 0x086) written to the kick register. A completed key sequence admits exactly one following bus write. The configuration register and the control register are always writable. They select the tick rate, the interrupt style, the gating of the reset request, the watchdog or periodic function, and a lock bit that cannot be undone.

The bus has no flow control: a write takes effect on the clock edge where `bus_we` is high, and `bus_rdata` is a combinational view of the addressed register. There is no streaming data path. All pins are plain control and status signals.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset both preloads read 0xFFFFF. The status, kick, configuration and control registers read 0. `irq_o`, `irq_hi_o` and `wdt_reset_o` are low. Reset also clears a set lock bit.
- R2: A write to a preload at 0x00 or 0x04 takes effect only if it is the bus write immediately after the key writes 0x080 then 0x086 to the kick register at 0x0C. Any later write needs a fresh key sequence.
- R3: Any bus write that is not the expected next key step returns the key sequence to its start. This includes a write of the wrong value, a write to another address, or a repeated first key. A guarded write that follows such a break is ignored.
- R4: Configuration register 0x10, bit 2 = 1 selects the fast tick (one tick per 32 clocks). In this mode, stage one expires 32*(P1+1) clocks after the enabling write, where P1 is the stage-one preload.
- R5: In watchdog function, stage two expires 32*(P2+1) clocks after stage one expires. On expiry `wdt_reset_o` rises and bit 9 of the kick register reads 1 with no key sequence.
- R6: A guarded write of bit 8 to the kick register restarts stage one from P1 and the tick divider. The same write without the key sequence is ignored.
- R7: Once asserted, `wdt_reset_o` stays high until a guarded write of bit 9 to the kick register clears the flag. An unguarded clear has no effect.
- R8: Configuration bit 5 = 1 holds `wdt_reset_o` low while the flag is still set. Clearing bit 5 exposes the set flag at once.
- R9: Configuration bits 1:0 select the interrupt on stage-one expiry. The codes are: 00 = level on `irq_o`, 01 = one-clock pulse on `irq_o`, 10 = level on `irq_hi_o`, 11 = none and the status stays 0. Status bit 0 at 0x08 is cleared by writing 1.
- R10: Control register 0x14 has lock at bit 0, enable at bit 1 and function select at bit 2. Writing 0 while unlocked disables the watchdog and reads back 0. With lock set, enable cannot be cleared, function select is frozen, and the watchdog still expires.
- R11: Function select = 1 gives a periodic timer. Stage one expires every 32*(P1+1) fast ticks' worth of clocks, reloads itself, never starts stage two and never sets the timeout flag.
- R12: Configuration bit 2 = 0 selects the slow tick (one tick per 32768 clocks). With P1 = 0, stage one expires 32768 clocks after enabling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 20 | Write data |
| bus_rdata | output | 20 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Stage-one interrupt, level or pulse |
| irq_hi_o | output | 1 | Stage-one interrupt on the high-priority line |
| wdt_reset_o | output | 1 | Reset request after stage-two expiry |

## Verification
On every cycle, the assertions check the following:
- A preload changes only on the write right after a completed key sequence.
- The timeout flag rises only out of stage two and falls only on a guarded clear.
- A completed key sequence is consumed by one write.
- Lock and a locked enable never fall.
- A pulse-type interrupt lasts one clock.

The exact expiry times need the bench's scenarios, which compare measured clock counts against 32*(P+1) arithmetic over a sweep of preloads and against the 32768-clock slow tick. The same holds for the effect of reloads, the interrupt styles, the reset gating and the periodic mode.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_PRE1  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_PRE2  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_ISTAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_KICK  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CFG   = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h14;

  localparam logic [15:0] KEY_FIRST  = 16'h0080;
  localparam logic [15:0] KEY_SECOND = 16'h0086;

  localparam int KICK_RELOAD_BIT = 8;
  localparam int KICK_CLEAR_BIT  = 9;

  localparam logic [1:0] IT_LEVEL = 2'b00;
  localparam logic [1:0] IT_PULSE = 2'b01;
  localparam logic [1:0] IT_HIGH  = 2'b10;
  localparam logic [1:0] IT_NONE  = 2'b11;

  typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_OPEN} unlock_t;
  typedef enum logic [1:0] {ST_OFF, ST_ONE, ST_TWO, ST_DONE} stage_t;

  typedef struct packed {
    logic       rst_gate;
    logic       fast;
    logic [1:0] itype;
  } cfg_t;
endpackage

// File: rtl/dsw_unlock.sv
module dsw_unlock import dsw_pkg::*; #(
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              open_o
);
  unlock_t st_q;
  logic    hit_kick;

  assign hit_kick = (wr_addr == OFF_KICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= UL_IDLE;
    end else if (wr_en) begin
      case (st_q)
        UL_IDLE:  st_q <= (hit_kick && wr_data == DATA_W'(KEY_FIRST)) ? UL_ARMED : UL_IDLE;
        UL_ARMED: st_q <= (hit_kick && wr_data == DATA_W'(KEY_SECOND)) ? UL_OPEN : UL_IDLE;
        default:  st_q <= UL_IDLE;
      endcase
    end
  end

  assign open_o = (st_q == UL_OPEN);
endmodule

// File: rtl/dsw_prescaler.sv
module dsw_prescaler #(
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic fast,
  output logic tick
);
  logic [SLOW_SHIFT-1:0] cnt_q;
  logic                  fast_wrap;
  logic                  slow_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || !run) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (FAST_SHIFT > 0) begin : g_fast_div
      assign fast_wrap = &cnt_q[FAST_SHIFT-1:0];
    end else begin : g_fast_every
      assign fast_wrap = 1'b1;
    end
  endgenerate

  assign slow_wrap = &cnt_q;
  assign tick      = run && !restart && (fast ? fast_wrap : slow_wrap);
endmodule

// File: rtl/dsw_stages.sv
module dsw_stages import dsw_pkg::*; #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             tick,
  input  logic             timer_mode,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  output logic             one_done,
  output logic             two_done,
  output stage_t           stage_o
);
  stage_t           stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;
  logic             step;

  assign at_zero  = (cnt_q == '0);
  assign step     = enable && !start && tick;
  assign one_done = step && (stage_q == ST_ONE) && at_zero;
  assign two_done = step && (stage_q == ST_TWO) && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_OFF;
      cnt_q   <= '0;
    end else if (start) begin
      stage_q <= ST_ONE;
      cnt_q   <= pre1;
    end else if (!enable) begin
      stage_q <= ST_OFF;
    end else if (tick) begin
      case (stage_q)
        ST_ONE: begin
          if (!at_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (timer_mode) begin
            cnt_q <= pre1;
          end else begin
            stage_q <= ST_TWO;
            cnt_q   <= pre2;
          end
        end
        ST_TWO: begin
          if (!at_zero) cnt_q <= cnt_q - 1'b1;
          else          stage_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt import dsw_pkg::*; #(
  parameter int CNT_W      = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              irq_hi_o,
  output logic              wdt_reset_o
);
  localparam logic [CNT_W-1:0] PRE_RESET = '1;

  logic             unlock_open;
  logic             grant;
  logic [CNT_W-1:0] pre1_q, pre2_q;
  cfg_t             cfg_q;
  logic             lock_q, en_q, tmode_q;
  logic             istat_q, pulse_q, flag_q;
  logic             wr_kick_g, wr_ctrl, wr_cfg, wr_istat;
  logic             start, tick, one_done, two_done;
  stage_t           stage_q;

  dsw_unlock #(.DATA_W(CNT_W)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .open_o(unlock_open)
  );

  assign grant     = bus_we && unlock_open;
  assign wr_kick_g = grant && (bus_addr == OFF_KICK);
  assign wr_ctrl   = bus_we && (bus_addr == OFF_CTRL);
  assign wr_cfg    = bus_we && (bus_addr == OFF_CFG);
  assign wr_istat  = bus_we && (bus_addr == OFF_ISTAT);

  assign start = (wr_ctrl && bus_wdata[1] && !en_q)
               || (wr_kick_g && bus_wdata[KICK_RELOAD_BIT]);

  // Guarded preloads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1_q <= PRE_RESET;
      pre2_q <= PRE_RESET;
    end else if (grant) begin
      if (bus_addr == OFF_PRE1) pre1_q <= bus_wdata;
      if (bus_addr == OFF_PRE2) pre2_q <= bus_wdata;
    end
  end

  // Open configuration and control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      lock_q  <= 1'b0;
      en_q    <= 1'b0;
      tmode_q <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_q.rst_gate <= bus_wdata[5];
        cfg_q.fast     <= bus_wdata[2];
        cfg_q.itype    <= bus_wdata[1:0];
      end
      if (wr_ctrl) begin
        lock_q <= lock_q | bus_wdata[0];
        en_q   <= bus_wdata[1] | (lock_q & en_q);
        if (!lock_q) tmode_q <= bus_wdata[2];
      end
    end
  end

  dsw_prescaler #(.SLOW_SHIFT(SLOW_SHIFT), .FAST_SHIFT(FAST_SHIFT)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(start),
    .fast(cfg_q.fast), .tick(tick)
  );

  dsw_stages #(.CNT_W(CNT_W)) u_stages (
    .clk(clk), .rst_n(rst_n), .enable(en_q), .start(start), .tick(tick),
    .timer_mode(tmode_q), .pre1(pre1_q), .pre2(pre2_q),
    .one_done(one_done), .two_done(two_done), .stage_o(stage_q)
  );

  // Interrupt status, pulse and sticky timeout flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istat_q <= 1'b0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= one_done && (cfg_q.itype == IT_PULSE);
      if (one_done && cfg_q.itype != IT_NONE) istat_q <= 1'b1;
      else if (wr_istat && bus_wdata[0])      istat_q <= 1'b0;
      if (two_done)                                         flag_q <= 1'b1;
      else if (wr_kick_g && bus_wdata[KICK_CLEAR_BIT])      flag_q <= 1'b0;
    end
  end

  assign irq_o       = ((cfg_q.itype == IT_LEVEL) && istat_q)
                     || ((cfg_q.itype == IT_PULSE) && pulse_q);
  assign irq_hi_o    = (cfg_q.itype == IT_HIGH) && istat_q;
  assign wdt_reset_o = flag_q && !cfg_q.rst_gate;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_PRE1:  bus_rdata = pre1_q;
      OFF_PRE2:  bus_rdata = pre2_q;
      OFF_ISTAT: bus_rdata[0] = istat_q;
      OFF_KICK:  bus_rdata[KICK_CLEAR_BIT] = flag_q;
      OFF_CFG: begin
        bus_rdata[5]   = cfg_q.rst_gate;
        bus_rdata[2]   = cfg_q.fast;
        bus_rdata[1:0] = cfg_q.itype;
      end
      OFF_CTRL:  bus_rdata[2:0] = {tmode_q, en_q, lock_q};
      default: ;
    endcase
  end
endmodule

// File: rtl/dsw_checker.sv
module dsw_checker import dsw_pkg::*; #(
  parameter int CNT_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              kick_clr,
  input logic              unlock_open,
  input logic [CNT_W-1:0]  pre1,
  input logic              lock,
  input logic              en,
  input logic              flag,
  input logic              in_two,
  input logic [1:0]        itype,
  input logic              irq
);
  // R2: stage-one preload moves only on the write right after a key sequence
  p_preload_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pre1) |-> $past(bus_we && bus_addr == OFF_PRE1 && unlock_open));

  // R3: an opened guard is consumed by the next write
  p_unlock_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unlock_open && bus_we) |-> !unlock_open);

  // R5: timeout flag rises only out of stage two
  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(in_two));

  // R7: timeout flag falls only on a guarded clear
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(bus_we && bus_addr == OFF_KICK && kick_clr && unlock_open));

  // R10: lock is sticky and holds enable
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> lock);
  p_en_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock && en) |-> en);

  // R9: pulse-style interrupt lasts a single clock
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && itype == IT_PULSE) |=> !(irq && itype == IT_PULSE));
endmodule

bind dual_stage_wdt dsw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .kick_clr(bus_wdata[KICK_CLEAR_BIT]), .unlock_open(unlock_open),
  .pre1(pre1_q), .lock(lock_q), .en(en_q), .flag(flag_q),
  .in_two(stage_q == ST_TWO), .itype(cfg_q.itype), .irq(irq_o)
);

// File: tb/dual_stage_wdt_test.sv
`timescale 1ns/1ps
module dual_stage_wdt_test;
  import dsw_pkg::*;
  localparam int W = 20;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq, irqh, wrst;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_stage_wdt uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_o(irq), .irq_hi_o(irqh), .wdt_reset_o(wrst)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input int d);
    @(negedge clk); we = 1'b1; addr = a; wdata = W'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pwr(input logic [4:0] a, input int d);
    wr(OFF_KICK, 'h80); wr(OFF_KICK, 'h86); wr(a, d);
  endtask

  task automatic rdchk(input logic [4:0] a, input int exp, input string tag);
    int d;
    @(negedge clk); addr = a; #1 d = int'(rdata);
    chk(tag, d, exp);
  endtask

  task automatic wait_evt(input int which, input int t0, input int limit, output int dt);
    int n;
    n = 0; dt = -1;
    while (n < limit) begin
      logic s;
      s = (which == 0) ? irq : ((which == 1) ? irqh : wrst);
      if (s) begin dt = cyc - t0; break; end
      @(negedge clk); n++;
    end
  endtask

  task automatic cleanup();
    wr(OFF_CTRL, 0); pwr(OFF_KICK, 'h200); wr(OFF_ISTAT, 1);
  endtask

  initial begin
    int t0, t1, dt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdchk(OFF_PRE1, 'hFFFFF, "R1 pre1 reset");
    rdchk(OFF_PRE2, 'hFFFFF, "R1 pre2 reset");
    rdchk(OFF_ISTAT, 0, "R1 status reset");
    rdchk(OFF_KICK, 0, "R1 kick reset");
    rdchk(OFF_CFG, 0, "R1 cfg reset");
    rdchk(OFF_CTRL, 0, "R1 ctrl reset");
    chk("R1 outputs low", int'({irq, irqh, wrst}), 0);

    // R2 guarded preload writes
    wr(OFF_PRE1, 5);
    rdchk(OFF_PRE1, 'hFFFFF, "R2 unguarded write ignored");
    pwr(OFF_PRE1, 3);
    rdchk(OFF_PRE1, 3, "R2 guarded write taken");
    wr(OFF_PRE1, 7);
    rdchk(OFF_PRE1, 3, "R2 second write needs new key");
    for (int v = 0; v < 8; v++) begin
      pwr(OFF_PRE2, v * 37 + 1);
      rdchk(OFF_PRE2, v * 37 + 1, "R2 pre2 sweep");
    end

    // R3 broken sequences
    wr(OFF_KICK, 'h80); wr(OFF_CFG, 0); wr(OFF_KICK, 'h86); wr(OFF_PRE1, 9);
    rdchk(OFF_PRE1, 3, "R3 foreign write breaks key");
    wr(OFF_KICK, 'h80); wr(OFF_KICK, 'h80); wr(OFF_KICK, 'h86); wr(OFF_PRE1, 9);
    rdchk(OFF_PRE1, 3, "R3 repeated first key breaks");
    wr(OFF_KICK, 'h86); wr(OFF_KICK, 'h80); wr(OFF_PRE1, 9);
    rdchk(OFF_PRE1, 3, "R3 half key ignored");

    // R4 / R5 / R7 sweep over preloads, fast tick, level irq
    wr(OFF_CFG, 'h04);
    for (int p1 = 0; p1 < 3; p1++) begin
      for (int p2 = 0; p2 < 3; p2++) begin
        pwr(OFF_PRE1, p1); pwr(OFF_PRE2, p2);
        wr(OFF_CTRL, 'h2); t0 = cyc;
        wait_evt(0, t0, 400, dt);
        chk("R4 stage-one expiry time", dt, 32 * (p1 + 1));
        wait_evt(2, t0, 600, dt);
        chk("R5 stage-two expiry time", dt, 32 * (p1 + p2 + 2));
        rdchk(OFF_KICK, 'h200, "R5 flag readable without key");
        repeat (20) @(negedge clk);
        chk("R7 reset held", int'(wrst), 1);
        wr(OFF_KICK, 'h200);
        chk("R7 unguarded clear ignored", int'(wrst), 1);
        pwr(OFF_KICK, 'h200);
        chk("R7 guarded clear drops reset", int'(wrst), 0);
        rdchk(OFF_KICK, 0, "R7 flag cleared");
        wr(OFF_CTRL, 0); wr(OFF_ISTAT, 1);
        chk("R9 status clear drops irq", int'(irq), 0);
      end
    end

    // R6 reload
    pwr(OFF_PRE1, 3); pwr(OFF_PRE2, 5);
    wr(OFF_CTRL, 'h2); t0 = cyc;
    repeat (90) @(negedge clk);
    chk("R6 no expiry before reload", int'(irq), 0);
    pwr(OFF_KICK, 'h100); t1 = cyc;
    wait_evt(0, t1, 400, dt);
    chk("R6 reload restarts stage one", dt, 128);
    cleanup();
    wr(OFF_CTRL, 'h2); t0 = cyc;
    repeat (60) @(negedge clk);
    wr(OFF_KICK, 'h100);
    wait_evt(0, t0, 400, dt);
    chk("R6 unguarded reload ignored", dt, 128);
    cleanup();

    // R8 reset gating
    pwr(OFF_PRE1, 0); pwr(OFF_PRE2, 0);
    wr(OFF_CFG, 'h24); wr(OFF_CTRL, 'h2);
    repeat (80) @(negedge clk);
    chk("R8 gated reset low", int'(wrst), 0);
    rdchk(OFF_KICK, 'h200, "R8 flag set while gated");
    wr(OFF_CFG, 'h04);
    chk("R8 ungating exposes flag", int'(wrst), 1);
    cleanup();

    // R9 interrupt styles
    pwr(OFF_PRE1, 1); pwr(OFF_PRE2, 7);
    wr(OFF_CFG, 'h05); wr(OFF_CTRL, 'h2); t0 = cyc;
    wait_evt(0, t0, 200, dt);
    chk("R9 pulse time", dt, 64);
    @(negedge clk);
    chk("R9 pulse one clock", int'(irq), 0);
    rdchk(OFF_ISTAT, 1, "R9 status set by pulse style");
    chk("R9 pulse not on high line", int'(irqh), 0);
    cleanup();
    wr(OFF_CFG, 'h06); wr(OFF_CTRL, 'h2); t0 = cyc;
    wait_evt(1, t0, 200, dt);
    chk("R9 high line time", dt, 64);
    chk("R9 high style keeps irq_o low", int'(irq), 0);
    cleanup();
    wr(OFF_CFG, 'h07); wr(OFF_CTRL, 'h2);
    repeat (100) @(negedge clk);
    chk("R9 none style lines low", int'({irq, irqh}), 0);
    rdchk(OFF_ISTAT, 0, "R9 none style status clear");
    cleanup();

    // R11 periodic function
    wr(OFF_CFG, 'h04); pwr(OFF_PRE1, 1);
    wr(OFF_CTRL, 'h6); t0 = cyc;
    wait_evt(0, t0, 200, dt);
    chk("R11 first period", dt, 64);
    wr(OFF_ISTAT, 1);
    wait_evt(0, t0, 300, dt);
    chk("R11 second period", dt, 128);
    repeat (400) @(negedge clk);
    chk("R11 no reset in periodic mode", int'(wrst), 0);
    rdchk(OFF_KICK, 0, "R11 no flag in periodic mode");
    rdchk(OFF_CTRL, 6, "R11 ctrl readback");
    cleanup();

    // R12 slow tick
    wr(OFF_CFG, 'h00); pwr(OFF_PRE1, 0);
    wr(OFF_CTRL, 'h2); t0 = cyc;
    wait_evt(0, t0, 40000, dt);
    chk("R12 slow tick expiry", dt, 32768);
    cleanup();

    // R10 enable / lock
    wr(OFF_CFG, 'h04);
    wr(OFF_CTRL, 'h2);
    rdchk(OFF_CTRL, 2, "R10 enable reads back");
    wr(OFF_CTRL, 0);
    rdchk(OFF_CTRL, 0, "R10 unlocked disable");
    pwr(OFF_PRE1, 0); pwr(OFF_PRE2, 0);
    wr(OFF_CTRL, 'h3); t0 = cyc;
    wr(OFF_CTRL, 0);
    rdchk(OFF_CTRL, 3, "R10 lock keeps enable");
    wr(OFF_CTRL, 'h7);
    rdchk(OFF_CTRL, 3, "R10 function frozen by lock");
    wait_evt(2, t0, 300, dt);
    chk("R10 locked watchdog still expires", dt, 64);

    // R1 reset clears lock
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rdchk(OFF_CTRL, 0, "R1 reset clears lock");
    chk("R1 reset output low after reset", int'(wrst), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule